// File: doc/BRIEF.md
# SPI Register Access Slave

This block lets an external SPI master read and write a small bank of 24-bit registers. Every access is one 32-bit frame in SPI mode 0, most significant bit first, with the active-low select held low for the whole frame. The first eight bits form a header: a write flag in the top bit and a 7-bit register address below it. The remaining 24 bits carry the write data from the master. In the same frame, the slave shifts the addressed register's contents back on MISO, so a read needs no second transfer.

The three SPI inputs are brought into the system clock domain through two-flop synchronisers, and their edges are detected there. The system clock must run at least four times faster than SCLK. When the eighth header bit arrives, the register is fetched. Its data is then presented on MISO from the falling edge after that bit, so it is ready for the master's ninth rising edge.

A complete write frame produces a one-cycle strobe with the address and data. The strobe updates the internal register bank, and it is also visible at the ports for the rest of the chip.

Top module: `spi_regfile_slave`

## Requirements
- R1: After a write frame to an implemented address, a later read frame to that address returns the 24 written bits.
- R2: A frame is 32 bits, MSB first: bit 31 is the write flag (1 = write, 0 = read), bits 30:24 are the address and bits 23:0 are data. MISO returns 0 during bits 31:24 and the register contents during bits 23:0 of the same frame.
- R3: Addresses at or above NUM_REGS read as zero, and writing them changes no implemented register.
- R4: A frame whose select rises before 32 bits causes no strobe and no register change. A later shorter burst under a new select is not taken as its data phase.
- R5: A complete write frame gives exactly one system-clock pulse on wr_stb, with wr_addr and wr_data holding the frame's address and data.
- R6: A read frame produces no strobe.
- R7: While select is high, and after reset, MISO is 0.
- R8: SCLK edges beyond the 32nd within one select window are ignored: MISO stays 0, and the frame's single write is unaffected.
- R9: A write frame returns the register's previous contents on MISO in bits 23:0.
- R10: Raising select resets the bit counter, so a frame that follows an abort at any bit position decodes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | SPI clock, mode 0 |
| mosi | input | 1 | Serial data from the master |
| cs_n | input | 1 | Active-low frame select |
| miso | output | 1 | Serial data to the master |
| wr_stb | output | 1 | One-cycle pulse when a write frame completes |
| wr_addr | output | ADDR_W | Address of the completed write |
| wr_data | output | DATA_W | Data of the completed write |

## Verification
The hardest case to reach is a broken frame: select drops after only the header, and a new select then delivers exactly the 24 data bits that would have completed the frame. The bench produces this with a frame task that takes an explicit bit count. It runs an 8-bit write header and then a 24-bit burst carrying the data, and checks that no strobe appears and the register reads back unchanged. The same task also aborts a frame in the middle of the data phase and overruns a frame to 40 bits, which tests counter reset and saturation.

// File: rtl/spi_regfile_slave.sv
module spi_regfile_slave #(
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 24,
  parameter int NUM_REGS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              mosi,
  input  logic              cs_n,
  output logic              miso,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int HDR_LEN   = 1 + ADDR_W;
  localparam int FRAME_LEN = HDR_LEN + DATA_W;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);

  logic [2:0] sclk_q;
  logic [1:0] mosi_q;
  logic [1:0] cs_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_q <= '0;
      mosi_q <= '0;
      cs_q   <= '1;
    end else begin
      sclk_q <= {sclk_q[1:0], sclk};
      mosi_q <= {mosi_q[0], mosi};
      cs_q   <= {cs_q[0], cs_n};
    end

  wire sel       = ~cs_q[1];
  wire mosi_s    = mosi_q[1];
  wire sclk_rise = sclk_q[1] & ~sclk_q[2];
  wire sclk_fall = ~sclk_q[1] & sclk_q[2];

  logic [CNT_W-1:0]     bitcnt;
  logic [FRAME_LEN-2:0] shin;
  logic [DATA_W-1:0]    out_sh;
  logic                 hdr_w;
  logic [ADDR_W-1:0]    hdr_a;
  logic                 miso_r;
  logic [DATA_W-1:0]    regs [NUM_REGS];
  logic [DATA_W-1:0]    rd_word;

  wire              taking    = sel & sclk_rise & (bitcnt != CNT_W'(FRAME_LEN));
  wire              at_hdr    = bitcnt == CNT_W'(HDR_LEN - 1);
  wire              at_last   = bitcnt == CNT_W'(FRAME_LEN - 1);
  wire              in_data   = (bitcnt >= CNT_W'(HDR_LEN)) && (bitcnt < CNT_W'(FRAME_LEN));
  wire [ADDR_W-1:0] addr_now  = {shin[ADDR_W-2:0], mosi_s};
  wire              wflag_now = shin[ADDR_W-1];
  wire [DATA_W-1:0] data_now  = {shin[DATA_W-2:0], mosi_s};

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (addr_now == ADDR_W'(i)) rd_word = regs[i];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bitcnt  <= '0;
      shin    <= '0;
      out_sh  <= '0;
      hdr_w   <= 1'b0;
      hdr_a   <= '0;
      miso_r  <= 1'b0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (!sel) begin
        bitcnt <= '0;
        miso_r <= 1'b0;
        out_sh <= '0;
      end else begin
        if (taking) begin
          shin   <= {shin[FRAME_LEN-3:0], mosi_s};
          bitcnt <= bitcnt + 1'b1;
          if (at_hdr) begin
            hdr_w  <= wflag_now;
            hdr_a  <= addr_now;
            out_sh <= rd_word;
          end
          if (at_last && hdr_w) begin
            wr_stb  <= 1'b1;
            wr_addr <= hdr_a;
            wr_data <= data_now;
          end
        end
        if (sclk_fall) begin
          if (in_data) begin
            miso_r <= out_sh[DATA_W-1];
            out_sh <= out_sh << 1;
          end else begin
            miso_r <= 1'b0;
          end
        end
      end
    end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
        regs[g] <= '0;
      else if (wr_stb && wr_addr == ADDR_W'(g))
        regs[g] <= wr_data;
  end

  assign miso = miso_r;
endmodule

module spi_regfile_slave_chk #(
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 24,
  parameter int NUM_REGS = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       miso,
  input logic       wr_stb,
  input logic       sel,
  input logic [5:0] bitcnt
);
  localparam int FRAME_LEN = 1 + ADDR_W + DATA_W;

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  p_strobe_full_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (bitcnt == 6'(FRAME_LEN)));
  p_idle_miso_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel && $past(!sel)) |-> !miso);
  p_count_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!sel) |-> (bitcnt == 6'd0));
  p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= 6'(FRAME_LEN));
endmodule

bind spi_regfile_slave spi_regfile_slave_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .miso(miso), .wr_stb(wr_stb),
  .sel(sel), .bitcnt(6'(bitcnt))
);

// File: tb/sim_spi_regfile_slave.sv
`timescale 1ns/1ps
module sim_spi_regfile_slave;
  localparam int NREG = 16;
  localparam int HALF = 6;

  logic clk = 0, rst_n = 0, sclk = 0, mosi = 0, cs_n = 1;
  logic miso, wr_stb;
  logic [6:0] wr_addr;
  logic [23:0] wr_data;

  int vectors = 0, fails = 0;
  int stb_count = 0, quiet = 0;
  logic [6:0] last_addr;
  logic [23:0] last_data;
  logic [23:0] model [128];

  always #2 clk = ~clk;

  spi_regfile_slave u0 (.clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
    .miso(miso), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (wr_stb) begin
      stb_count++;
      last_addr = wr_addr;
      last_data = wr_data;
    end
    quiet = cs_n ? quiet + 1 : 0;
    if (rst_n && quiet > 4) begin
      check("R7 miso idle", {63'd0, miso}, 64'd0);
      check("R5 no strobe idle", {63'd0, wr_stb}, 64'd0);
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [63:0] word, input int nbits, output logic [63:0] got);
    got = '0;
    cs_n = 0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      mosi = word[nbits-1-i];
      wait_clk(HALF);
      got[nbits-1-i] = miso;
      sclk = 1;
      wait_clk(HALF);
      sclk = 0;
    end
    wait_clk(HALF);
    cs_n = 1;
    mosi = 0;
    wait_clk(8);
    if (nbits >= 32 && word[nbits-1] && word[nbits-2 -: 7] < NREG)
      model[word[nbits-2 -: 7]] = word[nbits-9 -: 24];
  endtask

  task automatic wr(input logic [6:0] a, input logic [23:0] d, input string req);
    logic [63:0] got;
    logic [23:0] old;
    int s0;
    old = model[a];
    s0 = stb_count;
    frame({32'd0, 1'b1, a, d}, 32, got);
    check({req, " R5 strobe count"}, 64'(stb_count - s0), 64'd1);
    check({req, " R5 strobe addr/data"}, {33'd0, last_addr, last_data}, {33'd0, a, d});
    check({req, " R9 old contents"}, got, {40'd0, old});
  endtask

  task automatic rd(input logic [6:0] a, input string req);
    logic [63:0] got;
    int s0;
    s0 = stb_count;
    frame({32'd0, 1'b0, a, 24'd0}, 32, got);
    check({req, " R2 read word"}, got, {40'd0, model[a]});
    check({req, " R6 no strobe"}, 64'(stb_count - s0), 64'd0);
  endtask

  initial begin
    logic [63:0] got;
    int s0;
    for (int i = 0; i < 128; i++) model[i] = '0;
    wait_clk(3);
    check("R7 reset miso", {63'd0, miso}, 64'd0);
    check("R5 reset strobe", {63'd0, wr_stb}, 64'd0);
    rst_n = 1;
    wait_clk(4);

    wr(7'h00, 24'hA5C3F0, "R1");
    wr(7'h05, 24'h123456, "R1");
    wr(7'h0F, 24'hFFFFFF, "R1");
    wr(7'h05, 24'h800001, "R9");
    rd(7'h00, "R1");
    rd(7'h05, "R1");
    rd(7'h0F, "R1");

    wr(7'h13, 24'h00BEEF, "R3");
    rd(7'h13, "R3 unimplemented");
    rd(7'h03, "R3 alias");
    rd(7'h7F, "R3 top address");

    s0 = stb_count;
    frame({56'd0, 8'h82}, 8, got);
    frame({40'd0, 24'h777777}, 24, got);
    check("R4 no strobe on broken frame", 64'(stb_count - s0), 64'd0);
    rd(7'h02, "R4");

    s0 = stb_count;
    frame({44'd0, 1'b1, 7'h04, 12'hABC}, 20, got);
    check("R10 abort mid-data no strobe", 64'(stb_count - s0), 64'd0);
    wr(7'h04, 24'h0F0F0F, "R10");
    rd(7'h04, "R10");

    s0 = stb_count;
    frame({24'd0, 1'b1, 7'h06, 24'h5A5A5A, 8'hFF}, 40, got);
    check("R8 one strobe on overrun", 64'(stb_count - s0), 64'd1);
    check("R8 data of first 32 bits", {40'd0, last_data}, {40'd0, 24'h5A5A5A});
    check("R8 miso zero after frame", {56'd0, got[7:0]}, 64'd0);
    rd(7'h06, "R8");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #600000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule